// File: doc/BRIEF.md
# DRAM Controller Event Counter Unit

This unit sits beside a DRAM controller and tallies eight kinds of controller activity: write data beats, read data beats, write commands, read commands, precharges, activates, rank switches and turns between read and write direction. The controller reports each occurrence as a one-cycle pulse on its own line. Each line feeds its own 32-bit counter, so the event-to-counter mapping is fixed. No event-select logic exists.

Software reaches the unit over a simple single-cycle register bus. Through it, software sets a global run bit and a per-counter enable mask, preloads or reads any counter, and handles wrap-around interrupts. Each counter has a sticky overflow flag. The single level-sensitive interrupt line is raised while any flag is set whose mask bit is clear. A typical use is to preload a counter near its top value, enable it, and take an interrupt when a chosen number of events has gone by.

Top module: `mcev_unit`

## Requirements
- R1: After reset every counter reads 0, the control and event-enable registers read 0, the mask register (0x6C8) reads 0xFF, the status register (0x6CC) reads 0 and `irq` is low.
- R2: Counter n (n = 0..7, at offsets 0x380, 0x384, 0x388, 0x38C, 0x3C0, 0x3C4, 0x3CC, 0x3D0 in that order) rises by one at the clock edge where `evt_pulse[n]` is high, bit 1 of the control register (0x010) is set and bit n of the event-enable register (0x6C0) is set.
- R3: While control bit 1 is clear, no counter changes on event pulses.
- R4: A counter whose event-enable bit is clear holds its value while other counters advance.
- R5: A write to a counter offset loads the written 32-bit value, and the load takes precedence over an event pulse in the same cycle.
- R6: When a counter steps from 0xFFFFFFFF to 0, it sets status bit n whether or not mask bit n is set.
- R7: `irq` is high exactly when some status bit n is set and mask bit n is clear (a mask bit of 1 blocks that counter).
- R8: Writing to 0x6D0 clears the status bits written as 1 and leaves the others. Writes to the status register itself have no effect.
- R9: If a counter overflows in the same cycle that its status bit is cleared, the bit ends up set.
- R10: Reads of unmapped offsets and of the clear register 0x6D0 return 0. The control register reads back only bit 1, and all other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as a read access |
| evt_pulse | input | 8 | One-cycle event strobes, bit n for counter n |
| irq | output | 1 | Level interrupt, OR of unmasked overflow flags |

## Verification
The bench applies event patterns that separate the counters from one another: one line at a time, all eight lines at once, and alternating halves. These patterns show whether the mapping is correct, whether lines are crossed, and whether the counters are truly independent. The same pulses are then repeated with the global run bit off and with a partial enable mask, so that each gating level is seen on its own. Counters preloaded near the top value push overflow, masking, selective clearing and the clash between an overflow and a clear into a few cycles. A behavioural model shadows every edge.

// File: rtl/mcev_pkg.sv
// Shared constants for the DRAM event counter unit.
// Assumes byte offsets of 12 bits and word-aligned registers.
package mcev_pkg;
    localparam int NUM_CTR = 8;
    localparam int CTR_W   = 32;
    localparam int ADDR_W  = 12;
    localparam int GEN_BIT = 1;

    localparam logic [ADDR_W-1:0] A_CTRL = 12'h010;
    localparam logic [ADDR_W-1:0] A_EVEN = 12'h6C0;
    localparam logic [ADDR_W-1:0] A_MASK = 12'h6C8;
    localparam logic [ADDR_W-1:0] A_STAT = 12'h6CC;
    localparam logic [ADDR_W-1:0] A_CLR  = 12'h6D0;

    // Counter offsets: four contiguous words, then a group with a gap after the second pair.
    function automatic logic [ADDR_W-1:0] ctr_offset(input int n);
        if (n < 4)
            return ADDR_W'(12'h380 + 4 * n);
        else
            return ADDR_W'(12'h3C0 + 4 * (n - 4) + ((n >= 6) ? 4 : 0));
    endfunction
endpackage

// File: rtl/mcev_counter.sv
// One event counter with preload.
// Assumes the load and increment qualifiers are already decoded upstream.
module mcev_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    // Count state: a preload beats an increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // Wrap strobe: an increment from all-ones without a competing load
    assign ovf = inc & ~load & (&cnt);
endmodule

// File: rtl/mcev_ovf_irq.sv
// Sticky overflow flags, interrupt mask and interrupt output.
// Assumes the clear strobe is a single-cycle write. Overflow outranks clear.
module mcev_ovf_irq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ovf,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_val,
    output logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] clr_eff;
    assign clr_eff = clr_wr ? clr_bits : '0;

    // Mask register: after reset every source is blocked
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '1;
        else if (mask_wr)
            mask <= mask_val;
    end

    // Sticky flags: write-one-to-clear, and a new overflow sets the bit again
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~clr_eff) | ovf;
    end

    // Level interrupt from the unmasked flags
    assign irq = |(status & ~mask);
endmodule

// File: rtl/mcev_unit.sv
// Top of the DRAM event counter unit: register decode, enables, counters and the read mux.
// Assumes a single-cycle register bus with combinational read data.
module mcev_unit
    import mcev_pkg::*;
#(
    parameter int CW = CTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CW-1:0]     reg_wdata,
    output logic [CW-1:0]     reg_rdata,
    input  logic [NUM_CTR-1:0] evt_pulse,
    output logic              irq
);
    localparam int N = NUM_CTR;

    logic              wr_en, rd_en;
    logic              glob_en;
    logic [N-1:0]      ev_en;
    logic [N-1:0]      ctr_load, ctr_inc, ovf;
    logic [N-1:0][CW-1:0] cnt_q;
    logic [N-1:0]      mask_q, status_q;
    logic              clr_hit, mask_hit;

    assign wr_en    = reg_sel & reg_wr;
    assign rd_en    = reg_sel & ~reg_wr;
    assign clr_hit  = wr_en && (reg_addr == A_CLR);
    assign mask_hit = wr_en && (reg_addr == A_MASK);

    // Global run bit and the per-counter enable mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            ev_en   <= '0;
        end else if (wr_en) begin
            if (reg_addr == A_CTRL) glob_en <= reg_wdata[GEN_BIT];
            if (reg_addr == A_EVEN) ev_en   <= reg_wdata[N-1:0];
        end
    end

    // One counter per event line, fixed mapping
    for (genvar i = 0; i < N; i++) begin : g_ctr
        assign ctr_load[i] = wr_en && (reg_addr == ctr_offset(i));
        assign ctr_inc[i]  = glob_en & ev_en[i] & evt_pulse[i];
        mcev_counter #(.W(CW)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (ctr_inc[i]),
            .load    (ctr_load[i]),
            .load_val(reg_wdata),
            .cnt     (cnt_q[i]),
            .ovf     (ovf[i])
        );
    end

    mcev_ovf_irq #(.N(N)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf     (ovf),
        .clr_wr  (clr_hit),
        .clr_bits(reg_wdata[N-1:0]),
        .mask_wr (mask_hit),
        .mask_val(reg_wdata[N-1:0]),
        .mask    (mask_q),
        .status  (status_q),
        .irq     (irq)
    );

    // Read mux: zero for unmapped and write-only offsets
    always_comb begin
        reg_rdata = '0;
        if (rd_en) begin
            case (reg_addr)
                A_CTRL:  reg_rdata[GEN_BIT] = glob_en;
                A_EVEN:  reg_rdata[N-1:0]   = ev_en;
                A_MASK:  reg_rdata[N-1:0]   = mask_q;
                A_STAT:  reg_rdata[N-1:0]   = status_q;
                default: ;
            endcase
            for (int i = 0; i < N; i++)
                if (reg_addr == ctr_offset(i)) reg_rdata = cnt_q[i];
        end
    end
endmodule

// File: rtl/mcev_unit_chk.sv
// Property checker for mcev_unit, attached by bind.
// Assumes it sees the internal enable, flag and counter state of the top.
module mcev_unit_chk #(
    parameter int N  = 8,
    parameter int CW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              glob_en,
    input logic [N-1:0]      ev_en,
    input logic [N-1:0]      mask,
    input logic [N-1:0]      status,
    input logic [N-1:0][CW-1:0] cnt,
    input logic [N-1:0]      ctr_load,
    input logic [N-1:0]      ovf,
    input logic              clr_hit,
    input logic [N-1:0]      clr_bits
);
    // R3: with the run bit clear and no preload, nothing moves
    a_r3_glob_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && ctr_load == '0) |=> $stable(cnt));

    // R7: a fully masked or flag-free unit stays quiet
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);
    a_r7_no_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // R4: a disabled counter holds unless preloaded
        a_r4_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev_en[i] && !ctr_load[i]) |=> $stable(cnt[i]));
        // R9: an overflow always leaves its flag set, even against a clear
        a_r9_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[i] |=> status[i]);
        // R8: a clear without a competing overflow drops the flag
        a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit && clr_bits[i] && !ovf[i]) |=> !status[i]);
        // R6: a flag only rises after a wrap of its own counter
        a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[i]) |-> $past(ovf[i]));
    end
endmodule

bind mcev_unit mcev_unit_chk #(.N(mcev_pkg::NUM_CTR), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .glob_en (glob_en),
    .ev_en   (ev_en),
    .mask    (mask_q),
    .status  (status_q),
    .cnt     (cnt_q),
    .ctr_load(ctr_load),
    .ovf     (ovf),
    .clr_hit (clr_hit),
    .clr_bits(reg_wdata[mcev_pkg::NUM_CTR-1:0])
);

// File: tb/mcev_unit_tb_top.sv
`timescale 1ns/1ps
// Bench for mcev_unit: behavioural shadow model updated on every edge,
// irq compared after every cycle and registers compared through reads.
module mcev_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_pulse = '0;
    logic        irq;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    mcev_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .irq(irq)
    );

    localparam logic [11:0] OFS [8] = '{12'h380, 12'h384, 12'h388, 12'h38C,
                                        12'h3C0, 12'h3C4, 12'h3CC, 12'h3D0};

    // Shadow model state
    logic [31:0] m_cnt [8];
    logic        m_gen = 1'b0;
    logic [7:0]  m_en = '0, m_mask = 8'hFF, m_stat = '0;

    initial for (int i = 0; i < 8; i++) m_cnt[i] = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_cnt[i] = '0;
            m_gen = 1'b0; m_en = '0; m_mask = 8'hFF; m_stat = '0;
        end else begin
            logic [7:0] o, c;
            o = '0; c = '0;
            for (int i = 0; i < 8; i++) begin
                if (reg_sel && reg_wr && reg_addr == OFS[i]) m_cnt[i] = reg_wdata;
                else if (m_gen && m_en[i] && evt_pulse[i]) begin
                    if (m_cnt[i] == 32'hFFFF_FFFF) o[i] = 1'b1;
                    m_cnt[i] = m_cnt[i] + 1;
                end
            end
            if (reg_sel && reg_wr) begin
                case (reg_addr)
                    12'h010: m_gen  = reg_wdata[1];
                    12'h6C0: m_en   = reg_wdata[7:0];
                    12'h6C8: m_mask = reg_wdata[7:0];
                    12'h6D0: c      = reg_wdata[7:0];
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~c) | o;
        end
    end

    function automatic logic [31:0] m_rd(input logic [11:0] a);
        for (int i = 0; i < 8; i++) if (a == OFS[i]) return m_cnt[i];
        case (a)
            12'h010: return {30'd0, m_gen, 1'b0};
            12'h6C0: return {24'd0, m_en};
            12'h6C8: return {24'd0, m_mask};
            12'h6CC: return {24'd0, m_stat};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // One bus/event cycle; irq is compared after the edge (R7)
    task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d, input logic [7:0] e);
        reg_sel = w; reg_wr = w; reg_addr = a; reg_wdata = d; evt_pulse = e;
        @(posedge clk); @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; evt_pulse = '0;
        check(irq == |(m_stat & ~m_mask), "R7 irq", {31'd0, irq}, {31'd0, |(m_stat & ~m_mask)});
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, a, d, 8'h00);
    endtask

    task automatic pulse(input logic [7:0] e);
        step(1'b0, 12'h000, 32'd0, e);
    endtask

    task automatic rd_chk(input logic [11:0] a, input string tag);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a; evt_pulse = '0;
        #1;
        check(reg_rdata == m_rd(a), tag, reg_rdata, m_rd(a));
        @(posedge clk); @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic rd_all_ctr(input string tag);
        for (int i = 0; i < 8; i++) rd_chk(OFS[i], tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd_all_ctr("R1 counter");
        rd_chk(12'h010, "R1 ctrl");
        rd_chk(12'h6C0, "R1 enable");
        rd_chk(12'h6C8, "R1 mask");
        rd_chk(12'h6CC, "R1 status");
        check(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);

        // R2: mapping under single, all-lines and alternating patterns
        wr(12'h010, 32'h2);
        wr(12'h6C0, 32'hFF);
        for (int i = 0; i < 8; i++) repeat (i + 1) pulse(8'(1 << i));
        rd_all_ctr("R2 single line");
        repeat (3) pulse(8'hFF);
        pulse(8'h55); pulse(8'hAA); pulse(8'h55);
        rd_all_ctr("R2 mixed lines");

        // R3: global run bit off
        wr(12'h010, 32'h0);
        repeat (4) pulse(8'hFF);
        rd_all_ctr("R3 global hold");

        // R4: partial enable mask
        wr(12'h010, 32'h2);
        wr(12'h6C0, 32'h0F);
        repeat (5) pulse(8'hFF);
        rd_all_ctr("R4 per-counter hold");

        // R5: preload, and preload against a same-cycle event
        wr(12'h3C4, 32'hFFFF_FFF0);
        rd_chk(12'h3C4, "R5 preload");
        step(1'b1, 12'h384, 32'h1234_5678, 8'h02);
        rd_chk(12'h384, "R5 load beats event");

        // R6: overflow while masked sets the flag, irq stays low
        wr(12'h6C0, 32'hFF);
        wr(12'h3C4, 32'hFFFF_FFFF);
        pulse(8'h20);
        rd_chk(12'h3C4, "R6 wrap to zero");
        rd_chk(12'h6CC, "R6 status while masked");
        check(irq == 1'b0, "R6 irq masked", {31'd0, irq}, 32'd0);

        // R7: unmask raises irq
        wr(12'h6C8, 32'hDF);
        check(irq == 1'b1, "R7 irq unmasked", {31'd0, irq}, 32'd1);

        // R8: status writes ignored, clear is selective
        wr(12'h380, 32'hFFFF_FFFF);
        pulse(8'h01);
        wr(12'h6CC, 32'h00);
        rd_chk(12'h6CC, "R8 status write ignored");
        wr(12'h6D0, 32'h01);
        rd_chk(12'h6CC, "R8 selective clear");
        wr(12'h6D0, 32'h20);
        rd_chk(12'h6CC, "R8 full clear");
        check(irq == 1'b0, "R8 irq after clear", {31'd0, irq}, 32'd0);

        // R9: overflow and clear in the same cycle
        wr(12'h3D0, 32'hFFFF_FFFF);
        pulse(8'h80);
        wr(12'h3D0, 32'hFFFF_FFFF);
        step(1'b1, 12'h6D0, 32'h80, 8'h80);
        rd_chk(12'h6CC, "R9 overflow wins");

        // R10: unmapped, clear register and control readback
        rd_chk(12'h004, "R10 unmapped");
        rd_chk(12'h3C8, "R10 gap");
        rd_chk(12'h6D0, "R10 clear reads zero");
        wr(12'h010, 32'hFFFF_FFFF);
        rd_chk(12'h010, "R10 ctrl bits");

        // R1: reset again restores everything
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        rd_all_ctr("R1 counter after reset");
        rd_chk(12'h6C8, "R1 mask after reset");
        rd_chk(12'h6CC, "R1 status after reset");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule